// File: doc/BRIEF.md
# Sparse Command Sequencer

This block is the top-level control state machine of a software-driven sponge-hash engine. Software writes a 6-bit command code over a simple write strobe. The block tracks the three phases of a sponge operation: idle, absorbing and squeezing. For each accepted command it sends a one-cycle strobe to an external permutation core. Command codes are sparse, so a single flipped bit cannot turn one valid command into another. Each code is accepted only in the phase where it makes sense. Any other write is rejected and flagged.

The block also holds the hash configuration: the hashing mode, the security strength and an override bit. It publishes the sponge rate selected by the stored strength. Before it lets a start command through, it checks that the mode and strength form a legal pair. The configuration is writable only while the engine is idle. A configuration write that arrives together with a start command is applied first, and the start is judged against the new values.

Top module: `sponge_cmd_seq`

## Requirements
- R1: After reset the block reports idle, drives no strobes and no error pulse, holds error code 0, opens the configuration write enable, and stores mode 0 with strength 0, so the published rate is 1344.
- R2: Exactly one of the three phase status outputs (idle, absorb, squeeze) is 1 in every cycle.
- R3: Start (code 6'h1D) written in idle with a legal configuration moves the block to absorb. It raises the start strobe for exactly the one cycle after the write.
- R4: Process (code 6'h2E) written in absorb moves the block to squeeze and raises the process strobe for one cycle.
- R5: Run (code 6'h31) written in squeeze raises the run strobe for one cycle and leaves the block in squeeze. It may be repeated any number of times.
- R6: Done (code 6'h16) written in squeeze returns the block to idle and raises the done strobe for one cycle.
- R7: A valid code written outside its phase leaves the phase unchanged and raises no strobe. It raises the error pulse and sets error code 1 (illegal command). Error code 2 means illegal configuration and 0 means none.
- R8: Any code other than the four valid ones leaves the phase unchanged, raises no strobe, and raises the error pulse with error code 1.
- R9: The rate output follows the stored strength code: 0→1344, 1→1152, 2→1088, 3→832, 4→576. Codes 5 to 7 give 0.
- R10: With mode 2 or mode 3, only strength codes 0 and 2 are legal. A start under any other pairing keeps the block idle and raises the error pulse with error code 2, unless the stored override bit is 1. In that case the start is accepted.
- R11: Mode code 1, or a strength code above 4, blocks a start with error code 2 even when the override bit is 1.
- R12: The configuration write enable is 1 exactly while idle. A configuration write made while not idle leaves the stored mode, strength and rate unchanged.
- R13: The error pulse lasts one cycle per rejected write. The error code holds its value until the next accepted start, which clears it to 0.
- R14: When a configuration write and a start arrive in the same idle cycle, the start is judged against the values being written, and those values are stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_we | input | 1 | Command write strobe |
| cmd_data | input | 6 | Sparse command code |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_mode | input | 2 | Hashing mode to write (0, 2, 3 legal) |
| cfg_strength | input | 3 | Strength code to write (0 to 4 defined) |
| cfg_override | input | 1 | Override bit to write; allows unsupported pairings |
| core_start | output | 1 | Start strobe to the permutation core |
| core_process | output | 1 | Process (finish absorbing) strobe |
| core_run | output | 1 | Extra-permutation strobe while squeezing |
| core_done | output | 1 | Done strobe; core clears its variables |
| st_idle | output | 1 | Idle phase status |
| st_absorb | output | 1 | Absorb phase status |
| st_squeeze | output | 1 | Squeeze phase status |
| cfg_wr_en | output | 1 | Configuration write enable (lock open) |
| cur_mode | output | 2 | Stored hashing mode |
| cur_strength | output | 3 | Stored strength code |
| rate_bits | output | 11 | Sponge rate in bits for the stored strength |
| err_pulse | output | 1 | One-cycle error indication |
| err_code | output | 2 | Latched error cause |

## Verification
Two events can meet in one idle cycle: a configuration write and a start command. The forwarding rule decides whether the start is accepted. The bench provokes this in both directions: an illegal stored configuration is overwritten by a legal one in the same cycle as a start, and a legal stored configuration is overwritten by an illegal one. The random phase also makes such collisions often. Each result is judged by a bench model that applies the write first, then checks legality, then predicts the phase, strobes and error code of the next cycle.

// File: rtl/sponge_seq_pkg.sv
package sponge_seq_pkg;

  localparam int CMD_W  = 6;
  localparam int MODE_W = 2;
  localparam int STR_W  = 3;
  localparam int RATE_W = 11;
  localparam int ERR_W  = 2;
  localparam int N_CMDS = 4;

  localparam logic [CMD_W-1:0] CODE_START   = 6'h1D;
  localparam logic [CMD_W-1:0] CODE_PROCESS = 6'h2E;
  localparam logic [CMD_W-1:0] CODE_RUN     = 6'h31;
  localparam logic [CMD_W-1:0] CODE_DONE    = 6'h16;

  localparam logic [MODE_W-1:0] MODE_SHA3     = 2'd0;
  localparam logic [MODE_W-1:0] MODE_RESERVED = 2'd1;
  localparam logic [STR_W-1:0]  STR_MAX       = 3'd4;

  typedef enum logic [1:0] {
    PH_IDLE    = 2'd0,
    PH_ABSORB  = 2'd1,
    PH_SQUEEZE = 2'd2
  } phase_e;

  typedef enum logic [ERR_W-1:0] {
    ERR_NONE = 2'd0,
    ERR_CMD  = 2'd1,
    ERR_CFG  = 2'd2
  } err_e;

  typedef struct packed {
    logic done;
    logic run;
    logic process;
    logic start;
  } cmd_vec_t;

  function automatic logic [RATE_W-1:0] rate_of(input logic [STR_W-1:0] s);
    logic [RATE_W-1:0] r;
    case (s)
      3'd0:    r = 11'd1344;
      3'd1:    r = 11'd1152;
      3'd2:    r = 11'd1088;
      3'd3:    r = 11'd832;
      3'd4:    r = 11'd576;
      default: r = '0;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/seq_cmd_decode.sv
module seq_cmd_decode
  import sponge_seq_pkg::*;
(
  input  logic             we_i,
  input  logic [CMD_W-1:0] code_i,
  output cmd_vec_t         hit_o,
  output logic             reserved_o
);

  localparam logic [N_CMDS*CMD_W-1:0] CODE_TABLE =
    {CODE_DONE, CODE_RUN, CODE_PROCESS, CODE_START};

  logic [N_CMDS-1:0] match;

  for (genvar i = 0; i < N_CMDS; i++) begin : g_match
    assign match[i] = we_i && (code_i == CODE_TABLE[i*CMD_W +: CMD_W]);
  end

  assign hit_o      = cmd_vec_t'(match);
  assign reserved_o = we_i && (match == '0);

endmodule

// File: rtl/seq_cfg_store.sv
module seq_cfg_store
  import sponge_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              open_i,
  input  logic              we_i,
  input  logic [MODE_W-1:0] mode_i,
  input  logic [STR_W-1:0]  str_i,
  input  logic              ovr_i,
  output logic [MODE_W-1:0] mode_o,
  output logic [STR_W-1:0]  str_o,
  output logic              legal_o
);

  logic              upd;
  logic [MODE_W-1:0] mode_q, eff_mode;
  logic [STR_W-1:0]  str_q, eff_str;
  logic              ovr_q, eff_ovr;
  logic              mode_ok, str_ok, pair_ok;

  assign upd = we_i && open_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_SHA3;
      str_q  <= '0;
      ovr_q  <= 1'b0;
    end else if (upd) begin
      mode_q <= mode_i;
      str_q  <= str_i;
      ovr_q  <= ovr_i;
    end
  end

  // A write accepted this cycle is forwarded to the legality check.
  always_comb begin
    eff_mode = upd ? mode_i : mode_q;
    eff_str  = upd ? str_i  : str_q;
    eff_ovr  = upd ? ovr_i  : ovr_q;
    mode_ok  = (eff_mode != MODE_RESERVED);
    str_ok   = (eff_str <= STR_MAX);
    pair_ok  = (eff_mode == MODE_SHA3) || (eff_str == 3'd0) || (eff_str == 3'd2);
    legal_o  = mode_ok && str_ok && (pair_ok || eff_ovr);
  end

  assign mode_o = mode_q;
  assign str_o  = str_q;

endmodule

// File: rtl/seq_phase_fsm.sv
module seq_phase_fsm
  import sponge_seq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  cmd_vec_t         hit_i,
  input  logic             reserved_i,
  input  logic             cfg_legal_i,
  output phase_e           phase_o,
  output cmd_vec_t         strobe_o,
  output logic             err_pulse_o,
  output logic [ERR_W-1:0] err_code_o
);

  phase_e           ph_q, ph_d;
  cmd_vec_t         stb_q, stb_d;
  logic             err_q, err_d;
  logic [ERR_W-1:0] code_q, code_d;
  logic             cmd_bad;

  always_comb begin
    ph_d    = ph_q;
    stb_d   = '0;
    err_d   = 1'b0;
    code_d  = code_q;
    cmd_bad = reserved_i;
    unique case (ph_q)
      PH_IDLE: begin
        if (hit_i.start) begin
          if (cfg_legal_i) begin
            ph_d        = PH_ABSORB;
            stb_d.start = 1'b1;
            code_d      = ERR_NONE;
          end else begin
            err_d  = 1'b1;
            code_d = ERR_CFG;
          end
        end else if (hit_i.process || hit_i.run || hit_i.done) begin
          cmd_bad = 1'b1;
        end
      end
      PH_ABSORB: begin
        if (hit_i.process) begin
          ph_d          = PH_SQUEEZE;
          stb_d.process = 1'b1;
        end else if (hit_i.start || hit_i.run || hit_i.done) begin
          cmd_bad = 1'b1;
        end
      end
      PH_SQUEEZE: begin
        if (hit_i.run) begin
          stb_d.run = 1'b1;
        end else if (hit_i.done) begin
          ph_d       = PH_IDLE;
          stb_d.done = 1'b1;
        end else if (hit_i.start || hit_i.process) begin
          cmd_bad = 1'b1;
        end
      end
      default: ph_d = PH_IDLE;
    endcase
    if (cmd_bad) begin
      err_d  = 1'b1;
      code_d = ERR_CMD;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= PH_IDLE;
      stb_q  <= '0;
      err_q  <= 1'b0;
      code_q <= ERR_NONE;
    end else begin
      ph_q   <= ph_d;
      stb_q  <= stb_d;
      err_q  <= err_d;
      code_q <= code_d;
    end
  end

  assign phase_o     = ph_q;
  assign strobe_o    = stb_q;
  assign err_pulse_o = err_q;
  assign err_code_o  = code_q;

endmodule

// File: rtl/sponge_cmd_seq.sv
module sponge_cmd_seq
  import sponge_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_we,
  input  logic [CMD_W-1:0]  cmd_data,
  input  logic              cfg_we,
  input  logic [MODE_W-1:0] cfg_mode,
  input  logic [STR_W-1:0]  cfg_strength,
  input  logic              cfg_override,
  output logic              core_start,
  output logic              core_process,
  output logic              core_run,
  output logic              core_done,
  output logic              st_idle,
  output logic              st_absorb,
  output logic              st_squeeze,
  output logic              cfg_wr_en,
  output logic [MODE_W-1:0] cur_mode,
  output logic [STR_W-1:0]  cur_strength,
  output logic [RATE_W-1:0] rate_bits,
  output logic              err_pulse,
  output logic [ERR_W-1:0]  err_code
);

  cmd_vec_t hit, strobe;
  logic     reserved, cfg_legal;
  phase_e   phase;

  seq_cmd_decode u_dec (
    .we_i       (cmd_we),
    .code_i     (cmd_data),
    .hit_o      (hit),
    .reserved_o (reserved)
  );

  seq_cfg_store u_cfg (
    .clk     (clk),
    .rst_n   (rst_n),
    .open_i  (cfg_wr_en),
    .we_i    (cfg_we),
    .mode_i  (cfg_mode),
    .str_i   (cfg_strength),
    .ovr_i   (cfg_override),
    .mode_o  (cur_mode),
    .str_o   (cur_strength),
    .legal_o (cfg_legal)
  );

  seq_phase_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .hit_i       (hit),
    .reserved_i  (reserved),
    .cfg_legal_i (cfg_legal),
    .phase_o     (phase),
    .strobe_o    (strobe),
    .err_pulse_o (err_pulse),
    .err_code_o  (err_code)
  );

  assign st_idle      = (phase == PH_IDLE);
  assign st_absorb    = (phase == PH_ABSORB);
  assign st_squeeze   = (phase == PH_SQUEEZE);
  assign cfg_wr_en    = st_idle;
  assign core_start   = strobe.start;
  assign core_process = strobe.process;
  assign core_run     = strobe.run;
  assign core_done    = strobe.done;
  assign rate_bits    = rate_of(cur_strength);

endmodule

// File: rtl/sponge_cmd_seq_chk.sv
module sponge_cmd_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cmd_we,
  input logic [5:0]  cmd_data,
  input logic        cfg_we,
  input logic [1:0]  cfg_mode,
  input logic [2:0]  cfg_strength,
  input logic        cfg_override,
  input logic        core_start,
  input logic        core_process,
  input logic        core_run,
  input logic        core_done,
  input logic        st_idle,
  input logic        st_absorb,
  input logic        st_squeeze,
  input logic        cfg_wr_en,
  input logic [1:0]  cur_mode,
  input logic [2:0]  cur_strength,
  input logic [10:0] rate_bits,
  input logic        err_pulse,
  input logic [1:0]  err_code
);

  logic code_reserved;
  assign code_reserved = (cmd_data != 6'h1D) && (cmd_data != 6'h2E) &&
                         (cmd_data != 6'h31) && (cmd_data != 6'h16);

  // R2
  status_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({st_idle, st_absorb, st_squeeze}) == 1);

  // R3
  strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({core_start, core_process, core_run, core_done}));

  // R3
  start_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    core_start |-> st_absorb && $past(st_idle) && err_code == 2'd0);

  // R4
  process_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    core_process |-> st_squeeze && $past(st_absorb));

  // R5
  run_stay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    core_run |-> st_squeeze && $past(st_squeeze));

  // R6
  done_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    core_done |-> st_idle && $past(st_squeeze));

  // R8
  reserved_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_we && code_reserved |=> err_pulse && err_code == 2'd1 &&
      $stable({st_idle, st_absorb, st_squeeze}));

  // R12
  cfg_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we && !cfg_wr_en |=> $stable(cur_mode) && $stable(cur_strength) &&
      $stable(rate_bits));

  // R13
  err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_pulse |-> err_code != 2'd0);

endmodule

bind sponge_cmd_seq sponge_cmd_seq_chk u_chk (.*);

// File: tb/sponge_cmd_seq_test.sv
module sponge_cmd_seq_test;

  logic        clk, rst_n;
  logic        cmd_we, cfg_we, cfg_override;
  logic [5:0]  cmd_data;
  logic [1:0]  cfg_mode;
  logic [2:0]  cfg_strength;
  logic        core_start, core_process, core_run, core_done;
  logic        st_idle, st_absorb, st_squeeze, cfg_wr_en, err_pulse;
  logic [1:0]  cur_mode, err_code;
  logic [2:0]  cur_strength;
  logic [10:0] rate_bits;

  int checks = 0;
  int errors = 0;

  // model state: phase 0 idle, 1 absorb, 2 squeeze
  int         m_ph;
  logic [1:0] m_mode, m_code;
  logic [2:0] m_str;
  logic       m_ovr;

  sponge_cmd_seq uut (.*);

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [10:0] exp_rate(input logic [2:0] s);
    case (s)
      3'd0: return 11'd1344;
      3'd1: return 11'd1152;
      3'd2: return 11'd1088;
      3'd3: return 11'd832;
      3'd4: return 11'd576;
      default: return 11'd0;
    endcase
  endfunction

  function automatic bit cfg_ok(input logic [1:0] md, input logic [2:0] s, input logic ov);
    if (md == 2'd1 || s > 3'd4) return 1'b0;
    if (md == 2'd0 || s == 3'd0 || s == 3'd2) return 1'b1;
    return ov;
  endfunction

  function automatic logic [26:0] observed();
    return {st_idle, st_absorb, st_squeeze, core_start, core_process, core_run,
            core_done, err_pulse, err_code, cfg_wr_en, cur_mode, cur_strength, rate_bits};
  endfunction

  function automatic logic [26:0] pack_exp(input int ph, input logic [3:0] stb,
      input logic ep, input logic [1:0] ec, input logic [1:0] md, input logic [2:0] s);
    return {ph == 0, ph == 1, ph == 2, stb, ep, ec, ph == 0, md, s, exp_rate(s)};
  endfunction

  task automatic compare(input logic [26:0] exp_v, input string tag);
    logic [26:0] act = observed();
    checks++;
    if (act !== exp_v) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp_v);
    end
  endtask

  // called at a negedge: drive, step the model, pass one posedge, compare
  task automatic cycle(input logic we, input logic [5:0] cd, input logic cwe,
      input logic [1:0] md, input logic [2:0] s, input logic ov, input string tag);
    bit         idle = (m_ph == 0);
    logic [1:0] e_md = (cwe && idle) ? md : m_mode;
    logic [2:0] e_s  = (cwe && idle) ? s  : m_str;
    logic       e_ov = (cwe && idle) ? ov : m_ovr;
    logic [3:0] stb  = 4'b0; // {start,process,run,done}
    logic       ep   = 1'b0;
    int         nph  = m_ph;
    cmd_we = we; cmd_data = cd; cfg_we = cwe;
    cfg_mode = md; cfg_strength = s; cfg_override = ov;
    if (we) begin
      case (cd)
        6'h1D: if (idle) begin
                 if (cfg_ok(e_md, e_s, e_ov)) begin nph = 1; stb = 4'b1000; m_code = 2'd0; end
                 else begin ep = 1'b1; m_code = 2'd2; end
               end else begin ep = 1'b1; m_code = 2'd1; end
        6'h2E: if (m_ph == 1) begin nph = 2; stb = 4'b0100; end
               else begin ep = 1'b1; m_code = 2'd1; end
        6'h31: if (m_ph == 2) stb = 4'b0010;
               else begin ep = 1'b1; m_code = 2'd1; end
        6'h16: if (m_ph == 2) begin nph = 0; stb = 4'b0001; end
               else begin ep = 1'b1; m_code = 2'd1; end
        default: begin ep = 1'b1; m_code = 2'd1; end
      endcase
    end
    m_mode = e_md; m_str = e_s; m_ovr = e_ov; m_ph = nph;
    @(negedge clk);
    compare(pack_exp(m_ph, stb, ep, m_code, m_mode, m_str), tag);
  endtask

  task automatic cmd(input logic [5:0] cd, input string tag);
    cycle(1'b1, cd, 1'b0, 2'd0, 3'd0, 1'b0, tag);
  endtask

  task automatic cfg(input logic [1:0] md, input logic [2:0] s, input logic ov, input string tag);
    cycle(1'b0, 6'h00, 1'b1, md, s, ov, tag);
  endtask

  task automatic idle_cycle(input string tag);
    cycle(1'b0, 6'h00, 1'b0, 2'd0, 3'd0, 1'b0, tag);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; cmd_we = 0; cmd_data = 0; cfg_we = 0;
    cfg_mode = 0; cfg_strength = 0; cfg_override = 0;
    m_ph = 0; m_mode = 0; m_str = 0; m_ovr = 0; m_code = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    compare(pack_exp(0, 4'b0, 1'b0, 2'd0, 2'd0, 3'd0), "R1 reset");

    cmd(6'h1D, "R3 start");
    idle_cycle("R3 strobe one cycle");
    cmd(6'h1D, "R7 start in absorb");
    idle_cycle("R13 code held");
    cfg(2'd2, 3'd1, 1'b0, "R12 cfg locked");
    cmd(6'h31, "R7 run in absorb");
    cmd(6'h2E, "R4 process");
    cmd(6'h31, "R5 run");
    cmd(6'h31, "R5 run again");
    cmd(6'h2E, "R7 process in squeeze");
    cmd(6'h00, "R8 reserved 00");
    cmd(6'h3F, "R8 reserved 3f");
    cmd(6'h1C, "R8 near start");
    cmd(6'h16, "R6 done");
    cmd(6'h16, "R7 done in idle");
    cmd(6'h31, "R7 run in idle");
    for (int s = 0; s < 8; s++) cfg(2'd0, 3'(s), 1'b0, "R9 rate");
    cfg(2'd2, 3'd1, 1'b0, "R10 shake l224");
    cmd(6'h1D, "R10 blocked");
    cfg(2'd3, 3'd4, 1'b0, "R10 cshake l512");
    cmd(6'h1D, "R10 blocked");
    cfg(2'd3, 3'd2, 1'b0, "R10 cshake l256");
    cmd(6'h1D, "R10 legal start");
    cmd(6'h2E, "R4 process");
    cmd(6'h16, "R6 done");
    cfg(2'd2, 3'd3, 1'b1, "R10 override");
    cmd(6'h1D, "R10 override start");
    cmd(6'h2E, "R4 process");
    cmd(6'h16, "R6 done");
    cfg(2'd1, 3'd0, 1'b1, "R11 reserved mode");
    cmd(6'h1D, "R11 blocked");
    cfg(2'd0, 3'd6, 1'b1, "R11 reserved strength");
    cmd(6'h1D, "R11 blocked");
    idle_cycle("R13 cfg code held");
    cycle(1'b1, 6'h1D, 1'b1, 2'd2, 3'd0, 1'b0, "R14 fwd legal");
    cmd(6'h2E, "R4 process");
    cmd(6'h16, "R6 done");
    cycle(1'b1, 6'h1D, 1'b1, 2'd3, 3'd1, 1'b0, "R14 fwd illegal");
    cmd(6'h1D, "R14 stored illegal");
    cfg(2'd0, 3'd0, 1'b0, "R12 cfg in idle");

    for (int i = 0; i < 4000; i++) begin
      logic [5:0] cd;
      logic [2:0] s;
      case ($urandom_range(0, 9))
        0, 1: cd = 6'h1D;
        2, 3: cd = 6'h2E;
        4, 5: cd = 6'h31;
        6:    cd = 6'h16;
        default: cd = 6'($urandom);
      endcase
      s = ($urandom_range(0, 3) == 0) ? 3'($urandom) : 3'($urandom_range(0, 4));
      cycle($urandom_range(0, 2) != 0, cd, $urandom_range(0, 3) == 0,
            2'($urandom), s, $urandom_range(0, 3) == 0, "R2 random");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule